// File: doc/BRIEF.md
# DMA Descriptor Fault Checker

This block screens a DMA channel descriptor at the moment the channel is activated and watches the bus for error responses while the channel runs. Alignment checks compare the source and destination addresses and their per-access step values against the access size of each side. A consistency check compares the per-request byte count with both access sizes and with the iteration count. The link address of a chained descriptor is checked against a power-of-two boundary. A request to abandon a channel is reported through the same status path.

Every fault event does three things. It pulses a cancel line to the loop engine. It raises a sticky per-channel interrupt request. If no earlier fault is held, it also latches a status record: eight fault flags, the channel that faulted, a cancelled indication and a summary valid bit. The record keeps the first fault until software clears it, so later faults cannot hide the root cause. All outputs are registered, and each one responds in the clock cycle after the stimulus.

Top module: `dma_cfg_checker`

## Requirements
- R1: Access-size code c (0 to 5) means 2^c bytes, and codes 6 and 7 are reserved. A descriptor check (chk_valid=1) with a defined source size sets err_flags[0] when src_addr is not a multiple of that size, and sets err_flags[1] when src_step is not a multiple of it.
- R2: The same rule applied to dst_size sets err_flags[2] for a misaligned dst_addr and err_flags[3] for a misaligned dst_step.
- R3: When link_en=1, err_flags[5] is set if the low 5 bits of next_desc (a 32-byte boundary) are not all zero. When link_en=0, next_desc is ignored.
- R4: err_flags[4] is set when minor_bytes is zero, when major_iter is zero, when either size code is reserved, or when minor_bytes is not a multiple of both access sizes.
- R5: A bus error response (bus_err=1) sets err_flags[6] when bus_err_dst=0 (read side) or err_flags[7] when bus_err_dst=1 (write side), and records bus_err_chan.
- R6: A cancel request sets err_cancelled with all eight flags zero, and records cancel_chan in err_chan.
- R7: err_valid is 1 exactly when a record is held, that is when some flag or err_cancelled is set. After reset every output is zero.
- R8: A held record is not changed by later faults until clear_status=1. A fault that arrives in the same cycle as the clear is latched as the new record.
- R9: When several fault events occur in one cycle, the record is taken from the descriptor check first, then the bus error, then the cancel request. A descriptor record carries all of its failing flags together.
- R10: cancel_out is high for exactly the one cycle after any fault event: a descriptor check with at least one flag, a bus error, or a cancel request.
- R11: err_irq[n] is set by every fault event on channel n, whether or not the record is held, and stays set until clear_status=1. A fault in the clearing cycle wins over the clear.
- R12: Every output reflects the inputs sampled at the previous rising clock edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Descriptor presented for checking this cycle |
| chk_chan | input | CHW | Channel owning the descriptor |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| src_size | input | 3 | Source access-size code |
| dst_size | input | 3 | Destination access-size code |
| src_step | input | OW | Signed source step per access |
| dst_step | input | OW | Signed destination step per access |
| minor_bytes | input | MW | Bytes per request |
| major_iter | input | IW | Iteration count |
| link_en | input | 1 | Descriptor chaining enabled |
| next_desc | input | AW | Address of the next descriptor |
| bus_err | input | 1 | Bus error response this cycle |
| bus_err_dst | input | 1 | 1 = write side, 0 = read side |
| bus_err_chan | input | CHW | Channel that took the bus error |
| cancel_req | input | 1 | Cancel request |
| cancel_chan | input | CHW | Channel being cancelled |
| clear_status | input | 1 | Clear the record and all interrupt requests |
| err_flags | output | 8 | Latched fault flags |
| err_chan | output | CHW | Channel of the latched fault |
| err_cancelled | output | 1 | Latched record is a cancel |
| err_valid | output | 1 | A record is held |
| cancel_out | output | 1 | Cancel pulse to the loop engine |
| err_irq | output | NCH | Per-channel error interrupt requests |

## Verification
Every result of this block, whether flags, channel, valid bit, cancel pulse or interrupt bits, is due exactly one rising edge after the inputs that cause it. The bench therefore drives a full input set on a falling edge, waits for the next falling edge, and compares all outputs there against a model updated for that single edge. Idle cycles that follow a fault confirm that the cancel pulse lasts one cycle and that a held record does not move. Random descriptors and events with a fixed seed, mixed with directed corner cases, exercise the priority and clear-collision rules in the same way.

// File: rtl/dma_cfgchk_pkg.sv
package dma_cfgchk_pkg;
   localparam int FLAG_W       = 8;
   localparam int F_SRC_ADDR   = 0;
   localparam int F_SRC_STEP   = 1;
   localparam int F_DST_ADDR   = 2;
   localparam int F_DST_STEP   = 3;
   localparam int F_COUNT      = 4;
   localparam int F_LINK       = 5;
   localparam int F_BUS_RD     = 6;
   localparam int F_BUS_WR     = 7;
   localparam int SZ_W         = 3;

   typedef logic [FLAG_W-1:0] fault_flags_t;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_CFG  = 2'd1,
      SRC_BUS  = 2'd2,
      SRC_CAN  = 2'd3
   } fault_src_e;
endpackage

// File: rtl/dma_size_align.sv
module dma_size_align #(
   parameter int AW     = 32,
   parameter int OW     = 16,
   parameter int MAX_SZ = 5
) (
   input  logic [2:0]    size_code,
   input  logic [AW-1:0] addr,
   input  logic [OW-1:0] step,
   output logic          size_ok,
   output logic [MAX_SZ-1:0] size_mask,
   output logic          addr_mis,
   output logic          step_mis
);
   always_comb begin
      size_ok = (int'(size_code) <= MAX_SZ);
      for (int i = 0; i < MAX_SZ; i++) begin
         size_mask[i] = size_ok && (i < int'(size_code));
      end
      addr_mis = |(addr[MAX_SZ-1:0] & size_mask);
      step_mis = |(step[MAX_SZ-1:0] & size_mask);
   end
endmodule

// File: rtl/dma_count_check.sv
module dma_count_check #(
   parameter int MW     = 16,
   parameter int IW     = 15,
   parameter int MAX_SZ = 5
) (
   input  logic              src_ok,
   input  logic              dst_ok,
   input  logic [MAX_SZ-1:0] src_mask,
   input  logic [MAX_SZ-1:0] dst_mask,
   input  logic [MW-1:0]     minor_bytes,
   input  logic [IW-1:0]     major_iter,
   output logic              count_bad
);
   logic zero_cnt, not_mult;
   always_comb begin
      zero_cnt  = (minor_bytes == '0) || (major_iter == '0);
      not_mult  = |(minor_bytes[MAX_SZ-1:0] & (src_mask | dst_mask));
      count_bad = zero_cnt || not_mult || !src_ok || !dst_ok;
   end
endmodule

// File: rtl/dma_fault_latch.sv
module dma_fault_latch
   import dma_cfgchk_pkg::*;
#(
   parameter int NCH = 16,
   parameter int CHW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_evt,
   input  fault_flags_t       cfg_flags,
   input  logic [CHW-1:0]     cfg_chan,
   input  logic               bus_evt,
   input  logic               bus_dst,
   input  logic [CHW-1:0]     bus_chan,
   input  logic               can_evt,
   input  logic [CHW-1:0]     can_chan,
   input  logic               clear,
   output fault_flags_t       flags_q,
   output logic [CHW-1:0]     chan_q,
   output logic               cancelled_q,
   output logic               valid_q,
   output logic               pulse_q,
   output logic [NCH-1:0]     irq_q
);
   fault_src_e     sel;
   fault_flags_t   sel_flags;
   logic [CHW-1:0] sel_chan;
   logic           any_evt;

   always_comb begin
      any_evt   = cfg_evt || bus_evt || can_evt;
      sel       = SRC_NONE;
      sel_flags = '0;
      sel_chan  = '0;
      if (cfg_evt) begin
         sel       = SRC_CFG;
         sel_flags = cfg_flags;
         sel_chan  = cfg_chan;
      end else if (bus_evt) begin
         sel       = SRC_BUS;
         sel_flags[F_BUS_RD] = !bus_dst;
         sel_flags[F_BUS_WR] = bus_dst;
         sel_chan  = bus_chan;
      end else if (can_evt) begin
         sel       = SRC_CAN;
         sel_chan  = can_chan;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q     <= '0;
         chan_q      <= '0;
         cancelled_q <= 1'b0;
         valid_q     <= 1'b0;
         pulse_q     <= 1'b0;
      end else begin
         pulse_q <= any_evt;
         if (clear || !valid_q) begin
            flags_q     <= sel_flags;
            chan_q      <= sel_chan;
            cancelled_q <= (sel == SRC_CAN);
            valid_q     <= any_evt;
         end
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_irq
      logic hit;
      assign hit = (cfg_evt && (int'(cfg_chan) == n)) ||
                   (bus_evt && (int'(bus_chan) == n)) ||
                   (can_evt && (int'(can_chan) == n));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q[n] <= 1'b0;
         else        irq_q[n] <= (irq_q[n] && !clear) || hit;
      end
   end
endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
   import dma_cfgchk_pkg::*;
#(
   parameter int NCH        = 16,
   parameter int AW         = 32,
   parameter int OW         = 16,
   parameter int MW         = 16,
   parameter int IW         = 15,
   parameter int MAX_SZ     = 5,
   parameter int LINK_LG    = 5,
   localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chk_valid,
   input  logic [CHW-1:0]     chk_chan,
   input  logic [AW-1:0]      src_addr,
   input  logic [AW-1:0]      dst_addr,
   input  logic [2:0]         src_size,
   input  logic [2:0]         dst_size,
   input  logic [OW-1:0]      src_step,
   input  logic [OW-1:0]      dst_step,
   input  logic [MW-1:0]      minor_bytes,
   input  logic [IW-1:0]      major_iter,
   input  logic               link_en,
   input  logic [AW-1:0]      next_desc,
   input  logic               bus_err,
   input  logic               bus_err_dst,
   input  logic [CHW-1:0]     bus_err_chan,
   input  logic               cancel_req,
   input  logic [CHW-1:0]     cancel_chan,
   input  logic               clear_status,
   output logic [7:0]         err_flags,
   output logic [CHW-1:0]     err_chan,
   output logic               err_cancelled,
   output logic               err_valid,
   output logic               cancel_out,
   output logic [NCH-1:0]     err_irq
);
   if (NCH < 2)            begin : g_bad_nch  $error("NCH must be at least 2"); end
   if (MAX_SZ > 7)         begin : g_bad_sz   $error("MAX_SZ exceeds the size code range"); end
   if (MAX_SZ > OW || MAX_SZ > AW || MAX_SZ > MW)
                           begin : g_bad_w    $error("field widths narrower than MAX_SZ"); end
   if (LINK_LG < 1 || LINK_LG > AW)
                           begin : g_bad_link $error("LINK_LG out of range"); end

   logic              s_ok, d_ok, s_amis, s_smis, d_amis, d_smis, cnt_bad, link_bad;
   logic [MAX_SZ-1:0] s_mask, d_mask;
   fault_flags_t      cfg_flags;

   dma_size_align #(.AW(AW), .OW(OW), .MAX_SZ(MAX_SZ)) u_src (
      .size_code(src_size), .addr(src_addr), .step(src_step),
      .size_ok(s_ok), .size_mask(s_mask), .addr_mis(s_amis), .step_mis(s_smis));

   dma_size_align #(.AW(AW), .OW(OW), .MAX_SZ(MAX_SZ)) u_dst (
      .size_code(dst_size), .addr(dst_addr), .step(dst_step),
      .size_ok(d_ok), .size_mask(d_mask), .addr_mis(d_amis), .step_mis(d_smis));

   dma_count_check #(.MW(MW), .IW(IW), .MAX_SZ(MAX_SZ)) u_cnt (
      .src_ok(s_ok), .dst_ok(d_ok), .src_mask(s_mask), .dst_mask(d_mask),
      .minor_bytes(minor_bytes), .major_iter(major_iter), .count_bad(cnt_bad));

   assign link_bad = link_en && (next_desc[LINK_LG-1:0] != '0);

   always_comb begin
      cfg_flags             = '0;
      cfg_flags[F_SRC_ADDR] = s_amis;
      cfg_flags[F_SRC_STEP] = s_smis;
      cfg_flags[F_DST_ADDR] = d_amis;
      cfg_flags[F_DST_STEP] = d_smis;
      cfg_flags[F_COUNT]    = cnt_bad;
      cfg_flags[F_LINK]     = link_bad;
   end

   dma_fault_latch #(.NCH(NCH), .CHW(CHW)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .cfg_evt(chk_valid && (cfg_flags != '0)), .cfg_flags(cfg_flags), .cfg_chan(chk_chan),
      .bus_evt(bus_err), .bus_dst(bus_err_dst), .bus_chan(bus_err_chan),
      .can_evt(cancel_req), .can_chan(cancel_chan), .clear(clear_status),
      .flags_q(err_flags), .chan_q(err_chan), .cancelled_q(err_cancelled),
      .valid_q(err_valid), .pulse_q(cancel_out), .irq_q(err_irq));
endmodule

// File: rtl/dma_cfg_checker_sva.sv
module dma_cfg_checker_sva #(
   parameter int NCH = 16,
   parameter int CHW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           chk_valid,
   input logic           bus_err,
   input logic           bus_err_dst,
   input logic           cancel_req,
   input logic [CHW-1:0] cancel_chan,
   input logic           clear_status,
   input logic [7:0]     err_flags,
   input logic [CHW-1:0] err_chan,
   input logic           err_cancelled,
   input logic           err_valid,
   input logic           cancel_out,
   input logic [NCH-1:0] err_irq
);
   a_r7_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> ((err_flags != '0) || err_cancelled));

   a_r7_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid |-> ((err_flags == '0) && !err_cancelled));

   a_r8_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !clear_status) |=>
         (err_valid && $stable(err_flags) && $stable(err_chan) && $stable(err_cancelled)));

   a_r6_cancel_record: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_valid && cancel_req && !bus_err && !chk_valid) |=>
         (err_cancelled && (err_chan == $past(cancel_chan)) && (err_flags == '0)));

   a_r5_write_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_valid && bus_err && bus_err_dst && !chk_valid) |=> (err_flags == 8'h80));

   a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err || cancel_req) |=> cancel_out);

   a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_out |-> $past(chk_valid || bus_err || cancel_req));

   a_r11_irq_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_req |=> err_irq[$past(cancel_chan)]);

   a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_status && !chk_valid && !bus_err && !cancel_req) |=> (err_irq == '0));
endmodule

bind dma_cfg_checker dma_cfg_checker_sva #(.NCH(NCH), .CHW(CHW)) u_sva (
   .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .bus_err(bus_err),
   .bus_err_dst(bus_err_dst), .cancel_req(cancel_req), .cancel_chan(cancel_chan),
   .clear_status(clear_status), .err_flags(err_flags), .err_chan(err_chan),
   .err_cancelled(err_cancelled), .err_valid(err_valid), .cancel_out(cancel_out),
   .err_irq(err_irq));

// File: tb/sim_dma_cfg_checker.sv
`timescale 1ns/1ps
module sim_dma_cfg_checker;
   localparam int NCH = 16;
   localparam int CHW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            chk_valid, link_en, bus_err, bus_err_dst, cancel_req, clear_status;
   logic [CHW-1:0]  chk_chan, bus_err_chan, cancel_chan;
   logic [31:0]     src_addr, dst_addr, next_desc;
   logic [2:0]      src_size, dst_size;
   logic [15:0]     src_step, dst_step, minor_bytes;
   logic [14:0]     major_iter;
   logic [7:0]      err_flags;
   logic [CHW-1:0]  err_chan;
   logic            err_cancelled, err_valid, cancel_out;
   logic [NCH-1:0]  err_irq;

   dma_cfg_checker #(.NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_chan(chk_chan),
      .src_addr(src_addr), .dst_addr(dst_addr), .src_size(src_size), .dst_size(dst_size),
      .src_step(src_step), .dst_step(dst_step), .minor_bytes(minor_bytes),
      .major_iter(major_iter), .link_en(link_en), .next_desc(next_desc),
      .bus_err(bus_err), .bus_err_dst(bus_err_dst), .bus_err_chan(bus_err_chan),
      .cancel_req(cancel_req), .cancel_chan(cancel_chan), .clear_status(clear_status),
      .err_flags(err_flags), .err_chan(err_chan), .err_cancelled(err_cancelled),
      .err_valid(err_valid), .cancel_out(cancel_out), .err_irq(err_irq));

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0]     m_flags;
   logic [CHW-1:0] m_chan;
   logic           m_can, m_valid, m_pulse;
   logic [NCH-1:0] m_irq;

   function automatic logic [4:0] sz_mask(input logic [2:0] c);
      if (c > 3'd5) return 5'd0;
      return 5'((32'd1 << c) - 1);
   endfunction

   function automatic logic [7:0] exp_flags();
      logic [7:0] f = '0;
      logic [4:0] ms = sz_mask(src_size);
      logic [4:0] md = sz_mask(dst_size);
      f[0] = (src_addr[4:0] & ms) != 0;
      f[1] = (src_step[4:0] & ms) != 0;
      f[2] = (dst_addr[4:0] & md) != 0;
      f[3] = (dst_step[4:0] & md) != 0;
      f[4] = (minor_bytes == 0) || (major_iter == 0) || (src_size > 3'd5) ||
             (dst_size > 3'd5) || ((minor_bytes[4:0] & (ms | md)) != 0);
      f[5] = link_en && (next_desc[4:0] != 0);
      return f;
   endfunction

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic idle();
      chk_valid = 0; chk_chan = 0; link_en = 0; next_desc = 0;
      src_addr = 32'h1000; dst_addr = 32'h2000; src_size = 3'd2; dst_size = 3'd2;
      src_step = 16'd4; dst_step = 16'd4; minor_bytes = 16'd16; major_iter = 15'd4;
      bus_err = 0; bus_err_dst = 0; bus_err_chan = 0;
      cancel_req = 0; cancel_chan = 0; clear_status = 0;
   endtask

   task automatic step(input string tag);
      logic [7:0]     f = exp_flags();
      logic           cfg = chk_valid && (f != 0);
      logic [7:0]     nf = '0;
      logic [CHW-1:0] nc = '0;
      logic           ncan = 0;
      logic           any = cfg || bus_err || cancel_req;
      logic [NCH-1:0] hits = '0;
      if (cfg) begin nf = f; nc = chk_chan; end
      else if (bus_err) begin nf = bus_err_dst ? 8'h80 : 8'h40; nc = bus_err_chan; end
      else if (cancel_req) begin ncan = 1; nc = cancel_chan; end
      if (cfg) hits[chk_chan] = 1;
      if (bus_err) hits[bus_err_chan] = 1;
      if (cancel_req) hits[cancel_chan] = 1;
      @(negedge clk);
      m_pulse = any;
      if (clear_status || !m_valid) begin
         m_flags = nf; m_chan = nc; m_can = ncan; m_valid = any;
      end
      m_irq = (clear_status ? '0 : m_irq) | hits;
      cmp(tag, "err_flags", 32'(err_flags), 32'(m_flags));
      cmp(tag, "err_chan", 32'(err_chan), 32'(m_chan));
      cmp(tag, "err_cancelled", 32'(err_cancelled), 32'(m_can));
      cmp(tag, "err_valid", 32'(err_valid), 32'(m_valid));
      cmp(tag, "cancel_out", 32'(cancel_out), 32'(m_pulse));
      cmp(tag, "err_irq", 32'(err_irq), 32'(m_irq));
      idle();
   endtask

   task automatic clr(input string tag);
      clear_status = 1; step(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd2024));
      idle();
      m_flags = 0; m_chan = 0; m_can = 0; m_valid = 0; m_pulse = 0; m_irq = 0;
      repeat (3) @(negedge clk);
      // R7: reset state
      cmp("R7", "reset flags", 32'(err_flags), 0);
      cmp("R7", "reset valid", 32'(err_valid), 0);
      cmp("R7", "reset irq", 32'(err_irq), 0);
      rst_n = 1;
      step("R7");
      // R1: clean descriptor, then misaligned source address and step
      chk_valid = 1; chk_chan = 4'd3; step("R1");
      chk_valid = 1; chk_chan = 4'd3; src_addr = 32'h1002; step("R1");
      clr("R11");
      chk_valid = 1; chk_chan = 4'd5; src_step = 16'hFFFE; step("R1");
      clr("R11");
      // R2: destination step misaligned to 8 bytes
      chk_valid = 1; chk_chan = 4'd6; dst_size = 3'd3; dst_addr = 32'h2008;
      dst_step = 16'd6; minor_bytes = 16'd8; step("R2");
      clr("R11");
      // R3: link alignment, and link_en=0 ignores next_desc
      chk_valid = 1; chk_chan = 4'd7; link_en = 1; next_desc = 32'h4010; step("R3");
      clr("R11");
      chk_valid = 1; chk_chan = 4'd7; link_en = 0; next_desc = 32'h4010; step("R3");
      chk_valid = 1; chk_chan = 4'd7; link_en = 1; next_desc = 32'h4020; step("R3");
      // R4: zero count, zero iterations, non-multiple, reserved size
      chk_valid = 1; chk_chan = 4'd1; minor_bytes = 0; step("R4");
      clr("R11");
      chk_valid = 1; chk_chan = 4'd1; major_iter = 0; step("R4");
      clr("R11");
      chk_valid = 1; chk_chan = 4'd1; minor_bytes = 16'd6; step("R4");
      clr("R11");
      chk_valid = 1; chk_chan = 4'd1; src_size = 3'd6; src_addr = 32'h1001; step("R4");
      clr("R11");
      // R5: read-side and write-side bus errors
      bus_err = 1; bus_err_dst = 0; bus_err_chan = 4'd9; step("R5");
      clr("R11");
      bus_err = 1; bus_err_dst = 1; bus_err_chan = 4'd10; step("R5");
      clr("R11");
      // R6: cancel request
      cancel_req = 1; cancel_chan = 4'd12; step("R6");
      // R10: pulse lasts one cycle; R8: record held
      step("R10");
      // R8 and R11: later fault does not overwrite, but raises its interrupt
      bus_err = 1; bus_err_chan = 4'd2; step("R8");
      step("R11");
      // R8: clear together with a new fault latches the new fault
      clear_status = 1; bus_err = 1; bus_err_dst = 1; bus_err_chan = 4'd4; step("R8");
      clr("R11");
      // R9: all three events in one cycle
      chk_valid = 1; chk_chan = 4'd8; dst_addr = 32'h2001; link_en = 1; next_desc = 32'h3;
      bus_err = 1; bus_err_chan = 4'd9; cancel_req = 1; cancel_chan = 4'd10; step("R9");
      clr("R11");
      bus_err = 1; bus_err_chan = 4'd9; cancel_req = 1; cancel_chan = 4'd10; step("R9");
      clr("R11");
      // R12: random traffic, every output checked one edge later
      for (int i = 0; i < 600; i++) begin
         chk_valid   = ($urandom % 10) < 6;
         chk_chan    = CHW'($urandom);
         src_size    = 3'($urandom % 7);
         dst_size    = 3'($urandom % 7);
         src_addr    = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFFFFE0);
         dst_addr    = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFFFFE0);
         src_step    = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom & 32'hFFE0);
         dst_step    = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom & 32'hFFE0);
         minor_bytes = ($urandom % 5 == 0) ? 16'($urandom % 8) : 16'(($urandom % 64) * 32);
         major_iter  = ($urandom % 8 == 0) ? 15'd0 : 15'($urandom);
         link_en     = $urandom % 2;
         next_desc   = ($urandom % 3 == 0) ? $urandom : ($urandom & 32'hFFFFFFE0);
         bus_err     = ($urandom % 8) == 0;
         bus_err_dst = $urandom % 2;
         bus_err_chan= CHW'($urandom);
         cancel_req  = ($urandom % 10) == 0;
         cancel_chan = CHW'($urandom);
         clear_status= ($urandom % 4) == 0;
         step("R12");
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule